// File: doc/BRIEF.md
# Synchronous SRAM with Late Writes and Zero Bus Turnaround

This block is a synthesizable behavioural model of a small synchronous static RAM. It is organised as 256 words of two 9-bit byte lanes. The address, the control inputs and the write data are sampled on the rising clock edge. Write data follows its command by a fixed number of edges. Because of this, a read can follow a write, and a write can follow a read, on consecutive cycles without an idle slot on the data bus.

A static strap selects the output timing:

- **Flow-through mode** (`flow_mode`=1): read data comes straight from the array. Write data follows its command by one edge.
- **Pipelined mode** (`flow_mode`=0): read data passes through an output register. Write data follows its command by two edges.

In pipelined mode a read can target a word whose write data has not yet reached the array. The read path then merges the incoming write bytes, lane by lane, over the stored word.

Four-beat bursts step the two low address bits, in linear or interleaved order. Two inputs act without a clock edge: an output enable and a sleep input. Both remove the read data from the outputs. Sleep also makes the sequencer ignore commands.

The sequencer is a four-state machine:

| State | Meaning |
|---|---|
| `ST_IDLE` | No burst is open. |
| `ST_RD_BURST` | A read burst is open. |
| `ST_WR_BURST` | A write burst is open. |
| `ST_ASLEEP` | The sleep input is high. |

Its transitions:

| Transition | From | To | Condition |
|---|---|---|---|
| start-read | any awake state | `ST_RD_BURST` | select without advance, `we`=0 |
| start-write | any awake state | `ST_WR_BURST` | select without advance, `we`=1 |
| advance | `ST_RD_BURST` or `ST_WR_BURST` | same state | advance; steps the beat and issues one more access of the same kind |
| deselect | any awake state | `ST_IDLE` | neither select nor a valid advance |
| doze | any state | `ST_ASLEEP` | sleep high |
| wake | `ST_ASLEEP` | `ST_IDLE`, or a start | sleep low |

Top module: `latewrite_sram`

## Requirements
- R1: An access starts only when all three bits of `cs_en` are 1 and `adv` is 0. With any enable bit at 0 (and no advance), the command is dropped: no read data appears and no word is written.
- R2: In flow-through mode (`flow_mode`=1), data for a read sampled at edge T is on `dout` with `dout_en`=1 during the cycle after edge T, before edge T+1.
- R3: In pipelined mode (`flow_mode`=0), data for a read sampled at edge T appears only after edge T+1, so a 4-beat burst delivers its beats on the 3-1-1-1 pattern.
- R4: Data for a write command sampled at edge T is taken from `din` at edge T+1 in flow-through mode and at edge T+2 in pipelined mode. `din` at every other edge has no effect.
- R5: Reads and writes may alternate on consecutive cycles. A pipelined read that targets a word whose write data arrives at the edge that loads the output register returns that new data.
- R6: Lane 0 is `din`/`dout` bits 8:0 and lane 1 is bits 17:9, with `byte_we[i]` enabling lane i. A disabled lane keeps its stored value, and the read merge takes only the enabled lanes of a pending write.
- R7: With `burst_ilv`=0, beat k of a burst reads or writes low address bits (start+k) mod 4, and the upper address bits stay fixed.
- R8: With `burst_ilv`=1, beat k uses low address bits start XOR k, and the upper address bits stay fixed.
- R9: `adv`=1 continues the open burst with the same direction. When no burst is open, `adv`=1 starts nothing and writes nothing.
- R10: `oe`=0 forces `dout_en` to 0 and `dout` to zero at once, without a clock edge.
- R11: `sleep`=1 forces `dout_en` to 0 at once. While `sleep` is sampled high, commands are dropped and any open burst is closed.
- R12: After reset, `dout_en` is 0, `dout` is zero and no burst is open.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all sampling is on the rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| flow_mode | input | 1 | Strap: 1 flow-through, 0 pipelined; held static outside reset |
| burst_ilv | input | 1 | Burst order: 1 interleaved, 0 linear |
| cs_en | input | 3 | Three chip enables, all must be 1 to select |
| adv | input | 1 | Advance the open burst by one beat |
| we | input | 1 | Direction of a new access: 1 write, 0 read |
| addr | input | 8 | Word address of a new access |
| byte_we | input | 2 | Per-lane write enables, sampled with the command |
| din | input | 18 | Late write data |
| oe | input | 1 | Asynchronous output enable, active high |
| sleep | input | 1 | Asynchronous power-down, active high |
| dout | output | 18 | Read data, zero when not driven |
| dout_en | output | 1 | High when `dout` carries read data |

## Verification
The properties assume that `flow_mode` changes only while `rst_n` is low. Their latency and forwarding checks read the strap as fixed across the cycles they span. The bench therefore changes the strap only inside its reset task. It also toggles `burst_ilv` only while no burst is open, so the burst-step properties always see a single ordering for the whole burst. `din` is driven with distinct filler words at the edges where it should be ignored. This lets a wrong write latency show up as a stored value rather than go unseen.

// File: rtl/lwsram_pkg.sv
package lwsram_pkg;

    typedef enum logic [1:0] {
        ST_IDLE     = 2'd0,
        ST_RD_BURST = 2'd1,
        ST_WR_BURST = 2'd2,
        ST_ASLEEP   = 2'd3
    } seq_state_e;

    localparam int BEAT_BITS = 2;

    // Low address bits of a burst beat: linear adds, interleaved XORs.
    function automatic logic [BEAT_BITS-1:0] beat_offset(
        input logic [BEAT_BITS-1:0] start,
        input logic [BEAT_BITS-1:0] beat,
        input logic                 ilv
    );
        return ilv ? (start ^ beat) : (start + beat);
    endfunction

endpackage

// File: rtl/lwsram_seq.sv
module lwsram_seq
    import lwsram_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int LANES  = 2,
    parameter int NCS    = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sleep_i,
    input  logic              ilv_i,
    input  logic              adv_i,
    input  logic              we_i,
    input  logic [NCS-1:0]    cs_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [LANES-1:0]  be_i,
    output logic              iss_vld,
    output logic              iss_wr,
    output logic [ADDR_W-1:0] iss_addr,
    output logic [LANES-1:0]  iss_be
);

    localparam int BB = BEAT_BITS;

    seq_state_e        state, nxt_state;
    logic [ADDR_W-1:0] base_q, nxt_base;
    logic [BB-1:0]     beat_q, nxt_beat;
    logic              nxt_vld, nxt_wr, do_start, do_step, selected;

    assign selected = &cs_i;

    // Next-state decision
    always_comb begin
        do_start  = 1'b0;
        do_step   = 1'b0;
        nxt_state = state;
        if (sleep_i) begin
            nxt_state = ST_ASLEEP;                       // doze
        end else begin
            unique case (state)
                ST_RD_BURST, ST_WR_BURST: begin
                    if (adv_i)         do_step   = 1'b1; // advance
                    else if (selected) do_start  = 1'b1;
                    else               nxt_state = ST_IDLE; // deselect
                end
                ST_IDLE, ST_ASLEEP: begin
                    if (!adv_i && selected) do_start  = 1'b1;
                    else                    nxt_state = ST_IDLE; // wake / deselect
                end
            endcase
            if (do_start)
                nxt_state = we_i ? ST_WR_BURST : ST_RD_BURST; // start-write / start-read
        end
    end

    // Issue slot contents
    always_comb begin
        nxt_base = do_start ? addr_i : base_q;
        if (do_start)     nxt_beat = '0;
        else if (do_step) nxt_beat = beat_q + 1'b1;
        else              nxt_beat = beat_q;
        nxt_vld = do_start | do_step;
        nxt_wr  = do_start ? we_i : (state == ST_WR_BURST);
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            base_q <= '0;
            beat_q <= '0;
        end else begin
            state  <= nxt_state;
            base_q <= nxt_base;
            beat_q <= nxt_beat;
        end
    end

    // Output register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            iss_vld  <= 1'b0;
            iss_wr   <= 1'b0;
            iss_addr <= '0;
            iss_be   <= '0;
        end else begin
            iss_vld  <= nxt_vld;
            iss_wr   <= nxt_vld & nxt_wr;
            iss_addr <= {nxt_base[ADDR_W-1:BB], beat_offset(nxt_base[BB-1:0], nxt_beat, ilv_i)};
            iss_be   <= be_i;
        end
    end

    // R1: a partial select with no advance issues nothing
    p_partial_select_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (!sleep_i && !adv_i && !(&cs_i)) |=> !iss_vld);

    // R9: advance with no open burst issues nothing
    p_adv_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && adv_i && !sleep_i) |=> !iss_vld);

    // R11: a sampled sleep drops the command
    p_sleep_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
        sleep_i |=> !iss_vld);

    // R7: a linear advance steps the low bits by one inside the block
    p_linear_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (adv_i && !sleep_i && !ilv_i && (state == ST_RD_BURST || state == ST_WR_BURST))
        |=> (iss_vld && iss_addr[BB-1:0] == $past(iss_addr[BB-1:0]) + 2'd1
             && iss_addr[ADDR_W-1:BB] == $past(iss_addr[ADDR_W-1:BB])));

    // R8: an interleaved advance stays inside the 4-word block and moves
    p_ilv_block_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (adv_i && !sleep_i && ilv_i && (state == ST_RD_BURST || state == ST_WR_BURST))
        |=> (iss_vld && iss_addr[BB-1:0] != $past(iss_addr[BB-1:0])
             && iss_addr[ADDR_W-1:BB] == $past(iss_addr[ADDR_W-1:BB])));

endmodule

// File: rtl/lwsram_bank.sv
module lwsram_bank #(
    parameter int ADDR_W = 8,
    parameter int LANE_W = 9,
    parameter int LANES  = 2
) (
    input  logic                    clk,
    input  logic                    wr_en,
    input  logic [ADDR_W-1:0]       wr_addr,
    input  logic [LANES-1:0]        wr_lane,
    input  logic [LANES*LANE_W-1:0] wr_data,
    input  logic [ADDR_W-1:0]       rd_addr,
    output logic [LANES*LANE_W-1:0] rd_data
);

    localparam int DEPTH = 1 << ADDR_W;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [LANE_W-1:0] mem [DEPTH];

        always_ff @(posedge clk) begin
            if (wr_en && wr_lane[g])
                mem[wr_addr] <= wr_data[g*LANE_W +: LANE_W];
        end

        assign rd_data[g*LANE_W +: LANE_W] = mem[rd_addr];
    end

endmodule

// File: rtl/lwsram_rdpath.sv
module lwsram_rdpath #(
    parameter int ADDR_W = 8,
    parameter int LANE_W = 9,
    parameter int LANES  = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    flow_i,
    input  logic                    iss_vld,
    input  logic                    iss_wr,
    input  logic [ADDR_W-1:0]       iss_addr,
    input  logic [LANES*LANE_W-1:0] arr_data,
    input  logic                    pend_vld,
    input  logic [ADDR_W-1:0]       pend_addr,
    input  logic [LANES-1:0]        pend_be,
    input  logic [LANES*LANE_W-1:0] din_i,
    output logic [LANES*LANE_W-1:0] rd_data,
    output logic                    rd_vld
);

    localparam int DW = LANES * LANE_W;

    logic [DW-1:0] merged, rd_q;
    logic          rd_vld_q, hit, is_rd;

    assign is_rd = iss_vld & ~iss_wr;
    assign hit   = pend_vld && (pend_addr == iss_addr);

    // Lane-wise merge of write data that lands at this edge
    for (genvar g = 0; g < LANES; g++) begin : g_merge
        assign merged[g*LANE_W +: LANE_W] = (hit && pend_be[g]) ? din_i[g*LANE_W +: LANE_W]
                                                                 : arr_data[g*LANE_W +: LANE_W];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_q     <= '0;
            rd_vld_q <= 1'b0;
        end else begin
            rd_vld_q <= is_rd;
            if (is_rd) rd_q <= merged;
        end
    end

    assign rd_data = flow_i ? arr_data : rd_q;
    assign rd_vld  = flow_i ? is_rd : rd_vld_q;

    // R5: a pipelined read of a word completed at the loading edge returns the new data
    p_forward_full_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!flow_i && is_rd && hit && pend_be == {LANES{1'b1}}) |=> (rd_data == $past(din_i)));

endmodule

// File: rtl/latewrite_sram.sv
module latewrite_sram #(
    parameter int ADDR_W = 8,
    parameter int LANE_W = 9,
    parameter int LANES  = 2,
    parameter int NCS    = 3
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    flow_mode,
    input  logic                    burst_ilv,
    input  logic [NCS-1:0]          cs_en,
    input  logic                    adv,
    input  logic                    we,
    input  logic [ADDR_W-1:0]       addr,
    input  logic [LANES-1:0]        byte_we,
    input  logic [LANES*LANE_W-1:0] din,
    input  logic                    oe,
    input  logic                    sleep,
    output logic [LANES*LANE_W-1:0] dout,
    output logic                    dout_en
);

    localparam int DW = LANES * LANE_W;

    logic              iss_vld, iss_wr;
    logic [ADDR_W-1:0] iss_addr;
    logic [LANES-1:0]  iss_be;

    logic              s2_wr;
    logic [ADDR_W-1:0] s2_addr;
    logic [LANES-1:0]  s2_be;

    logic              cm_we;
    logic [ADDR_W-1:0] cm_addr;
    logic [LANES-1:0]  cm_be;

    logic [DW-1:0]     arr_data, rd_data;
    logic              rd_vld;

    lwsram_seq #(.ADDR_W(ADDR_W), .LANES(LANES), .NCS(NCS)) i_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .sleep_i  (sleep),
        .ilv_i    (burst_ilv),
        .adv_i    (adv),
        .we_i     (we),
        .cs_i     (cs_en),
        .addr_i   (addr),
        .be_i     (byte_we),
        .iss_vld  (iss_vld),
        .iss_wr   (iss_wr),
        .iss_addr (iss_addr),
        .iss_be   (iss_be)
    );

    // Second late-write stage, used by pipelined mode
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s2_wr   <= 1'b0;
            s2_addr <= '0;
            s2_be   <= '0;
        end else begin
            s2_wr   <= iss_vld & iss_wr;
            s2_addr <= iss_addr;
            s2_be   <= iss_be;
        end
    end

    assign cm_we   = flow_mode ? (iss_vld & iss_wr) : s2_wr;
    assign cm_addr = flow_mode ? iss_addr : s2_addr;
    assign cm_be   = flow_mode ? iss_be : s2_be;

    lwsram_bank #(.ADDR_W(ADDR_W), .LANE_W(LANE_W), .LANES(LANES)) i_bank (
        .clk     (clk),
        .wr_en   (cm_we),
        .wr_addr (cm_addr),
        .wr_lane (cm_be),
        .wr_data (din),
        .rd_addr (iss_addr),
        .rd_data (arr_data)
    );

    lwsram_rdpath #(.ADDR_W(ADDR_W), .LANE_W(LANE_W), .LANES(LANES)) i_rdpath (
        .clk       (clk),
        .rst_n     (rst_n),
        .flow_i    (flow_mode),
        .iss_vld   (iss_vld),
        .iss_wr    (iss_wr),
        .iss_addr  (iss_addr),
        .arr_data  (arr_data),
        .pend_vld  (~flow_mode & s2_wr),
        .pend_addr (s2_addr),
        .pend_be   (s2_be),
        .din_i     (din),
        .rd_data   (rd_data),
        .rd_vld    (rd_vld)
    );

    assign dout_en = oe & ~sleep & rd_vld;
    assign dout    = dout_en ? rd_data : '0;

    // R4: a pipelined commit belongs to a write issued the cycle before
    p_wr_latency_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!flow_mode && $stable(flow_mode) && cm_we) |-> $past(iss_vld && iss_wr));

    // R3: pipelined read data comes from a read slot one cycle older
    p_rd_latency_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!flow_mode && $stable(flow_mode) && rd_vld) |-> $past(iss_vld && !iss_wr));

endmodule

// File: tb/test_latewrite_sram.sv
module test_latewrite_sram;

    localparam int CLK_NS = 20;
    localparam logic [2:0] ON  = 3'b111;
    localparam logic [2:0] OFF = 3'b000;

    logic        clk = 1'b0;
    logic        rst_n, flow_mode, burst_ilv, adv, we, oe, sleep, dout_en;
    logic [2:0]  cs_en;
    logic [7:0]  addr;
    logic [1:0]  byte_we;
    logic [17:0] din, dout;

    int n_cmp = 0;
    int n_bad = 0;

    always #(CLK_NS/2) clk = ~clk;

    latewrite_sram i_latewrite_sram (
        .clk(clk), .rst_n(rst_n), .flow_mode(flow_mode), .burst_ilv(burst_ilv),
        .cs_en(cs_en), .adv(adv), .we(we), .addr(addr), .byte_we(byte_we),
        .din(din), .oe(oe), .sleep(sleep), .dout(dout), .dout_en(dout_en)
    );

    localparam logic [17:0] F1 = 18'h2A5C3, F2 = 18'h13579, F3 = 18'h0BEEF;
    localparam logic [17:0] P1 = 18'h3C0A5, OLD = 18'h12345, NEW = 18'h3ABCD;
    localparam logic [17:0] V1 = 18'h1F0F0, V2 = 18'h00777, V3 = 18'h25555;

    task automatic chk(input string req, input logic [17:0] act, input logic [17:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Drive one command at the negedge, return at the following negedge
    task automatic cyc(input logic [2:0] c, input logic a, input logic w,
                       input logic [7:0] ad, input logic [1:0] b, input logic [17:0] d);
        cs_en = c; adv = a; we = w; addr = ad; byte_we = b; din = d;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic nop(input logic [17:0] d);
        cyc(OFF, 1'b0, 1'b0, 8'h00, 2'b00, d);
    endtask

    task automatic do_reset(input logic fm);
        rst_n = 1'b0; flow_mode = fm; burst_ilv = 1'b0;
        cs_en = OFF; adv = 0; we = 0; addr = 0; byte_we = 0; din = 0; oe = 1; sleep = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        chk("R12 reset dout_en", {17'd0, dout_en}, 18'd0);
        chk("R12 reset dout", dout, 18'd0);
    endtask

    task automatic t_flow_basic();
        cyc(ON, 0, 1, 8'h10, 2'b11, 18'h00111);   // write cmd, din here ignored
        nop(F1);                                  // data one edge later
        nop(18'h00222);
        cyc(ON, 0, 0, 8'h10, 2'b11, 18'h00333);
        chk("R2 flow read same cycle", dout, F1);
        chk("R4 flow single late write en", {17'd0, dout_en}, 18'd1);
    endtask

    task automatic t_flow_rwr();
        cyc(ON, 0, 1, 8'h12, 2'b11, 18'h00444);
        cyc(ON, 0, 0, 8'h12, 2'b11, F2);
        chk("R5 flow read right after write", dout, F2);
        cyc(ON, 0, 1, 8'h12, 2'b11, 18'h00555);
        chk("R5 flow write slot no output", {17'd0, dout_en}, 18'd0);
        cyc(ON, 0, 0, 8'h12, 2'b11, F3);
        chk("R5 flow read after second write", dout, F3);
    endtask

    task automatic t_flow_burst();
        burst_ilv = 1'b0;
        cyc(ON, 0, 1, 8'h34, 2'b11, 18'h0);
        for (int k = 0; k < 3; k++) cyc(OFF, 1, 0, 8'h00, 2'b11, 18'h1A0 + 18'(k));
        nop(18'h1A3);
        burst_ilv = 1'b1;
        cyc(ON, 0, 0, 8'h35, 2'b11, 18'h0);
        chk("R8 ilv beat0", dout, 18'h1A1);
        cyc(OFF, 1, 0, 8'h00, 2'b00, 18'h0);
        chk("R8 ilv beat1", dout, 18'h1A0);
        cyc(OFF, 1, 0, 8'h00, 2'b00, 18'h0);
        chk("R8 ilv beat2", dout, 18'h1A3);
        cyc(OFF, 1, 0, 8'h00, 2'b00, 18'h0);
        chk("R8 ilv beat3", dout, 18'h1A2);
        nop(18'h0);
        burst_ilv = 1'b0;
        cyc(ON, 0, 0, 8'h36, 2'b11, 18'h0);
        chk("R7 linear beat0", dout, 18'h1A2);
        cyc(OFF, 1, 0, 8'h00, 2'b00, 18'h0);
        chk("R7 linear beat1", dout, 18'h1A3);
        cyc(OFF, 1, 0, 8'h00, 2'b00, 18'h0);
        chk("R7 linear wrap beat2", dout, 18'h1A0);
        cyc(OFF, 1, 0, 8'h00, 2'b00, 18'h0);
        chk("R9 advance continues read", dout, 18'h1A1);
        nop(18'h0);
    endtask

    task automatic t_adv_idle();
        nop(18'h0);
        cyc(ON, 1, 1, 8'h10, 2'b11, 18'h0);
        chk("R9 advance while idle no output", {17'd0, dout_en}, 18'd0);
        nop(18'h3FFFF);
        nop(18'h3FFFF);
        cyc(ON, 0, 0, 8'h10, 2'b11, 18'h0);
        chk("R9 advance while idle no write", dout, F1);
        nop(18'h0);
    endtask

    task automatic t_pipe_latency();
        cyc(ON, 0, 1, 8'h20, 2'b11, 18'h00AAA);
        nop(18'h00BBB);                          // one edge later: ignored in pipelined mode
        nop(P1);                                 // two edges later: taken
        nop(18'h00CCC);
        cyc(ON, 0, 0, 8'h20, 2'b11, 18'h0);
        chk("R3 pipe no data yet", {17'd0, dout_en}, 18'd0);
        nop(18'h0);
        chk("R4 pipe double late write", dout, P1);
        chk("R3 pipe data after next edge", {17'd0, dout_en}, 18'd1);
    endtask

    task automatic t_pipe_forward();
        cyc(ON, 0, 1, 8'h24, 2'b11, 18'h0);
        nop(18'h0);
        nop(OLD);
        nop(18'h0);
        cyc(ON, 0, 0, 8'h24, 2'b11, 18'h0);      // read
        cyc(ON, 0, 1, 8'h24, 2'b11, 18'h0);      // write, data two edges later
        chk("R5 pipe read before write", dout, OLD);
        cyc(ON, 0, 0, 8'h24, 2'b11, 18'h0);      // read again, no gap
        chk("R5 write slot output off", {17'd0, dout_en}, 18'd0);
        nop(NEW);
        chk("R5 forwarded full word", dout, NEW);
        cyc(ON, 0, 0, 8'h24, 2'b11, 18'h0);
        cyc(ON, 0, 1, 8'h24, 2'b01, 18'h0);
        cyc(ON, 0, 0, 8'h24, 2'b11, 18'h0);
        nop(OLD);
        chk("R6 forwarded lane 0 only", dout, {NEW[17:9], OLD[8:0]});
        nop(18'h0);
    endtask

    task automatic t_pipe_select();
        cyc(ON, 0, 1, 8'h40, 2'b11, 18'h0);
        nop(18'h0);
        nop(V1);
        cyc(3'b101, 0, 1, 8'h40, 2'b11, 18'h0);
        nop(18'h0);
        nop(V2);
        cyc(ON, 0, 0, 8'h40, 2'b11, 18'h0);
        nop(18'h0);
        chk("R1 partial select write dropped", dout, V1);
        cyc(3'b011, 0, 0, 8'h40, 2'b11, 18'h0);
        nop(18'h0);
        chk("R1 partial select read no output", {17'd0, dout_en}, 18'd0);
    endtask

    task automatic t_pipe_lanes();
        cyc(ON, 0, 1, 8'h40, 2'b10, 18'h0);
        nop(18'h0);
        nop(V3);
        cyc(ON, 0, 0, 8'h40, 2'b11, 18'h0);
        nop(18'h0);
        chk("R6 lane 1 written lane 0 kept", dout, {V3[17:9], V1[8:0]});
    endtask

    task automatic t_sleep_oe();
        sleep = 1'b1;
        cyc(ON, 0, 1, 8'h40, 2'b11, 18'h0);
        nop(18'h0);
        nop(V2);
        chk("R11 asleep output off", {17'd0, dout_en}, 18'd0);
        sleep = 1'b0;
        nop(18'h0);
        cyc(ON, 0, 0, 8'h40, 2'b11, 18'h0);
        nop(18'h0);
        chk("R11 write during sleep dropped", dout, {V3[17:9], V1[8:0]});
        sleep = 1'b1; #1;
        chk("R11 async sleep off", {17'd0, dout_en}, 18'd0);
        sleep = 1'b0; #1;
        chk("R11 wake output back", dout, {V3[17:9], V1[8:0]});
        oe = 1'b0; #1;
        chk("R10 async oe off enable", {17'd0, dout_en}, 18'd0);
        chk("R10 async oe off data", dout, 18'd0);
        oe = 1'b1; #1;
        chk("R10 oe back on", dout, {V3[17:9], V1[8:0]});
        @(negedge clk);
    endtask

    task automatic t_pipe_burst();
        burst_ilv = 1'b0;
        cyc(ON, 0, 0, 8'h36, 2'b11, 18'h0);
        chk("R3 pipe burst first beat not yet", {17'd0, dout_en}, 18'd0);
        cyc(OFF, 1, 0, 8'h00, 2'b00, 18'h0);
        chk("R3 pipe burst beat0", dout, 18'h1A2);
        cyc(OFF, 1, 0, 8'h00, 2'b00, 18'h0);
        chk("R7 pipe burst beat1", dout, 18'h1A3);
        cyc(OFF, 1, 0, 8'h00, 2'b00, 18'h0);
        chk("R7 pipe burst wrap", dout, 18'h1A0);
        nop(18'h0);
        chk("R3 pipe burst last beat", dout, 18'h1A1);
    endtask

    initial begin
        #(CLK_NS * 150000);
        n_bad++;
        $display("FAIL watchdog all requirements actual=timeout expected=finish");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        @(negedge clk);
        do_reset(1'b1);
        t_flow_basic();
        t_flow_rwr();
        t_flow_burst();
        t_adv_idle();
        do_reset(1'b0);
        t_pipe_latency();
        t_pipe_forward();
        t_pipe_select();
        t_pipe_lanes();
        t_sleep_oe();
        t_pipe_burst();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule